// File: doc/BRIEF.md
# Word-by-Halfword Signed Multiply-Accumulate Unit

This block multiplies a full signed 32-bit operand by one signed 16-bit half of a second operand. From the 48-bit signed product it keeps the upper 32 bits, which is bits 47:16. The low 16 bits are dropped. This gives a fractional-style scaled product, not an ordinary low-word multiply. In its accumulate mode the scaled product is also added to a 32-bit accumulator input, modulo 2^32. Any signed overflow of that addition is recorded in a sticky saturation flag.

An upstream issue stage presents one operation per cycle. Each operation carries an operation select, a half-select bit, the two operands, the accumulator and a valid strobe. The result appears one cycle later together with an output valid strobe. The sticky flag stays set across operations until reset or an explicit clear.

Top module: `whmac_unit`

## Requirements
- R1: After reset, `outValid` is 0, `result` is 0x00000000 and `sticky` is 0.
- R2: `outValid` is 1 in exactly the cycle after a cycle with `inValid` high, and 0 after a cycle with `inValid` low.
- R3: `halfSel` = 1 selects `opB[31:16]` and `halfSel` = 0 selects `opB[15:0]`. The selected half is treated as a signed 16-bit value.
- R4: With `opSel` = 0 (multiply only), `result` equals bits 47:16 of the signed 48-bit product of `opA` and the selected half.
- R5: With `opSel` = 1 (multiply-accumulate), `result` equals the R4 value plus `accIn`, modulo 2^32.
- R6: A multiply-accumulate whose addition overflows in the signed sense sets `sticky`. This covers both positive and negative overflow.
- R7: A multiply-only operation never changes `sticky`.
- R8: Once set, `sticky` holds until reset or until a cycle with `stickyClr` high. When an overflowing multiply-accumulate arrives in the same cycle as `stickyClr`, `sticky` ends at 1.
- R9: `result` keeps its last value while `inValid` is low.
- R10: 0x80000000 times a selected half of 0x8000 yields 0x40000000 with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 1 | 0 = multiply only, 1 = multiply-accumulate |
| halfSel | input | 1 | 1 = upper half of opB, 0 = lower half |
| opA | input | 32 | Full-width signed operand |
| opB | input | 32 | Operand supplying the 16-bit half |
| accIn | input | 32 | Accumulator addend |
| stickyClr | input | 1 | Clears the sticky flag at the next edge |
| outValid | output | 1 | Result valid |
| result | output | 32 | Scaled product or accumulated sum |
| sticky | output | 1 | Sticky signed-overflow flag |

## Verification
The hardest situation to reach from the ports is a stickyClr pulse that lands in the same cycle as an overflowing accumulate. The flag then has to end set. The stimulus first saturates the accumulator with a unit product, 0x00010000 times a half of 1, added to 0x7FFFFFFF. It then clears the flag with a lone pulse and repeats the overflowing operation with the clear asserted alongside it. The most negative operand pair is also driven, because its product sits exactly on the edge of the 48-bit range.

// File: rtl/whmac_pkg.sv
package whmac_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAC = 1'b1
  } whOp_e;

  typedef struct packed {
    logic load;
    logic accumulate;
    logic clearFlag;
  } whStrobe_t;
endpackage

// File: rtl/whmac_ctrl.sv
module whmac_ctrl
  import whmac_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      opSel,
  input  logic      stickyClr,
  output whStrobe_t strobes,
  output logic      outValid
);
  always_comb begin
    strobes.load       = inValid;
    strobes.accumulate = inValid && (whOp_e'(opSel) == OP_MAC);
    strobes.clearFlag  = stickyClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/whmac_datapath.sv
module whmac_datapath
  import whmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  whStrobe_t         strobes,
  input  logic              halfSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accIn,
  output logic [DATA_W-1:0] result,
  output logic              sticky
);
  localparam int PROD_W = DATA_W + HALF_W;

  logic [HALF_W-1:0] halfOp;
  logic signed [PROD_W-1:0] prodFull;
  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] nextResult;
  logic addOvf;

  generate
    if (DATA_W == 2 * HALF_W) begin : g_pairHalves
      assign halfOp = halfSel ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];
    end else begin : g_edgeHalves
      assign halfOp = halfSel ? opB[DATA_W-1 -: HALF_W] : opB[HALF_W-1:0];
    end
  endgenerate

  always_comb begin
    prodFull   = $signed({{HALF_W{opA[DATA_W-1]}}, opA}) *
                 $signed({{DATA_W{halfOp[HALF_W-1]}}, halfOp});
    scaled     = DATA_W'(prodFull >>> HALF_W);
    sum        = scaled + accIn;
    addOvf     = (scaled[DATA_W-1] == accIn[DATA_W-1]) &&
                 (sum[DATA_W-1] != scaled[DATA_W-1]);
    nextResult = strobes.accumulate ? sum : scaled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      sticky <= 1'b0;
    end else begin
      if (strobes.load) result <= nextResult;
      sticky <= (sticky & ~strobes.clearFlag) | (strobes.accumulate & addOvf);
    end
  end
endmodule

// File: rtl/whmac_unit.sv
module whmac_unit
  import whmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSel,
  input  logic              halfSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accIn,
  input  logic              stickyClr,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              sticky
);
  whStrobe_t strobes;

  whmac_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .stickyClr(stickyClr), .strobes(strobes), .outValid(outValid)
  );

  whmac_datapath #(.DATA_W(DATA_W), .HALF_W(HALF_W)) dpI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .halfSel(halfSel),
    .opA(opA), .opB(opB), .accIn(accIn), .result(result), .sticky(sticky)
  );
endmodule

// File: rtl/whmac_unit_chk.sv
module whmac_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              opSel,
  input logic              stickyClr,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              sticky
);
  // R2
  out_follows_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R7
  mul_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel && !stickyClr) |=> $stable(sticky));
  // R6
  flag_rise_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sticky) |-> $past(inValid && opSel));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stickyClr && !(inValid && opSel)) |=> !sticky);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
endmodule

bind whmac_unit whmac_unit_chk #(.DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
  .stickyClr(stickyClr), .outValid(outValid), .result(result), .sticky(sticky)
);

// File: tb/whmac_unit_test.sv
`timescale 1ns/1ps
module whmac_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic opSel = 1'b0;
  logic halfSel = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] accIn = '0;
  logic stickyClr = 1'b0;
  logic outValid;
  logic [31:0] result;
  logic sticky;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  whmac_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .halfSel(halfSel), .opA(opA), .opB(opB), .accIn(accIn),
    .stickyClr(stickyClr), .outValid(outValid), .result(result),
    .sticky(sticky)
  );

  function automatic logic [31:0] scaledModel(logic [31:0] a, logic [31:0] b, logic hs);
    longint sa = longint'(signed'(a));
    longint sh = hs ? longint'(signed'(b[31:16])) : longint'(signed'(b[15:0]));
    longint p = sa * sh;
    return p[47:16];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Issue one operation; on return the result registers hold its outcome.
  task automatic runOp(string req, logic op, logic hs, logic [31:0] a,
                       logic [31:0] b, logic [31:0] acc, logic clr,
                       logic [31:0] exp);
    @(negedge clk);
    inValid = 1'b1; opSel = op; halfSel = hs;
    opA = a; opB = b; accIn = acc; stickyClr = clr;
    @(negedge clk);
    inValid = 1'b0; stickyClr = 1'b0;
    check({req, " valid"}, {31'b0, outValid}, 32'd1);
    check(req, result, exp);
  endtask

  task automatic testReset;
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 result", result, 32'h0);
    check("R1 sticky", {31'b0, sticky}, 32'd0);
  endtask

  task automatic testLatency;
    runOp("R2", 1'b0, 1'b0, 32'h0002_0000, 32'h0000_0003, 32'h0, 1'b0, 32'h6);
    @(negedge clk);
    check("R2 drop", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testHalfSelect;
    runOp("R3 upper", 1'b0, 1'b1, 32'h0001_0000, 32'h1234_ABCD, 32'h0, 1'b0, 32'h0000_1234);
    runOp("R3 lower", 1'b0, 1'b0, 32'h0001_0000, 32'h1234_ABCD, 32'h0, 1'b0, 32'hFFFF_ABCD);
  endtask

  task automatic testMultiply;
    runOp("R4 maxpos", 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h0, 1'b0,
          scaledModel(32'h7FFF_FFFF, 32'h0000_7FFF, 1'b0));
    runOp("R4 mixed", 1'b0, 1'b1, 32'h8765_4321, 32'hC001_0000, 32'h0, 1'b0,
          scaledModel(32'h8765_4321, 32'hC001_0000, 1'b1));
    runOp("R4 negneg", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 1'b0,
          scaledModel(32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0));
    runOp("R10", 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 32'h4000_0000);
    check("R10 sticky", {31'b0, sticky}, 32'd0);
  endtask

  task automatic testAccumulate;
    runOp("R5 small", 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0005, 32'd10, 1'b0, 32'd15);
    runOp("R5 model", 1'b1, 1'b1, 32'h1357_9BDF, 32'h2468_0000, 32'hF000_0001, 1'b0,
          scaledModel(32'h1357_9BDF, 32'h2468_0000, 1'b1) + 32'hF000_0001);
    check("R5 no overflow", {31'b0, sticky}, 32'd0);
  endtask

  task automatic testSticky;
    runOp("R6 posovf", 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 32'h8000_0000);
    check("R6 set", {31'b0, sticky}, 32'd1);
    runOp("R7 mul", 1'b0, 1'b0, 32'h0001_0000, 32'h0000_0002, 32'h0, 1'b0, 32'h2);
    check("R7 kept 1", {31'b0, sticky}, 32'd1);
    runOp("R8 mac", 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0002, 32'd1, 1'b0, 32'd3);
    check("R8 held", {31'b0, sticky}, 32'd1);
    @(negedge clk); stickyClr = 1'b1;
    @(negedge clk); stickyClr = 1'b0;
    check("R8 cleared", {31'b0, sticky}, 32'd0);
    runOp("R7 mul2", 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 32'h4000_0000);
    check("R7 kept 0", {31'b0, sticky}, 32'd0);
    runOp("R6 negovf", 1'b1, 1'b0, 32'h0001_0000, 32'h0000_FFFF, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF);
    check("R6 neg set", {31'b0, sticky}, 32'd1);
    @(negedge clk); stickyClr = 1'b1;
    @(negedge clk); stickyClr = 1'b0;
    runOp("R8 clr+ovf", 1'b1, 1'b0, 32'h0001_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 32'h8000_0000);
    check("R8 set wins", {31'b0, sticky}, 32'd1);
  endtask

  task automatic testHold;
    runOp("R9 load", 1'b0, 1'b0, 32'h0003_0000, 32'h0000_0007, 32'h0, 1'b0, 32'd21);
    opA = 32'hFFFF_FFFF; opB = 32'h7FFF_7FFF; accIn = 32'h1234_5678; opSel = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 held", result, 32'd21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatency();
    testHalfSelect();
    testMultiply();
    testAccumulate();
    testSticky();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule